// File: doc/BRIEF.md
# SPI Flash Read-Path Command Front End

This block is the serial-side front end of a small SPI NOR flash device. It oversamples the chip-select, serial clock, hold and serial-input pins in a system clock domain that runs at least four times faster than the serial clock. It collects an 8-bit opcode, MSB first, and then any 24-bit address and dummy clocks the opcode needs. After that it streams bytes back on the serial output, fetching each byte through a synchronous byte-read port into a 32 KB array. The read port has one cycle of latency.

It serves plain read, fast read with one dummy byte, and a fast read that uses both data pins. It also serves three identification reads, each with its own byte order and looping rule. A hold input pauses the serial sequence without losing its position. Any opcode that is not a read is passed on as a one-cycle strobe with its code, for the program, erase and status logic that sits elsewhere. While that logic reports busy, only the status-read opcode is passed on.

Top module: `spi_rd_frontend`

## Requirements
- R1: After reset, and at any time chip select is high, so_oe and sio_oe are 0, no array read is issued and no command strobe fires.
- R2: Opcode 03h is followed by 24 address bits, MSB first. Only the low 15 bits select the byte and the upper 9 are ignored. The addressed byte is then shifted out MSB first on so_o alone, one bit per falling SCK edge, with sio_oe held at 0.
- R3: During a memory read the address advances by one after each byte, and 7FFFh is followed by 0000h. Streaming continues until chip select rises.
- R4: Opcode 0Bh behaves like 03h, except that 8 dummy clocks follow the address before the first data bit.
- R5: Opcode 3Bh takes an address and 8 dummy clocks. It then drives two bits per falling edge: bit 7/5/3/1 on so_o and bit 6/4/2/0 on sio_o, with both enables set. One byte takes 4 clocks.
- R6: Opcode 9Fh returns 7Fh, 9Dh, 2Fh, repeating while chip select stays low.
- R7: Opcode 90h takes 24 address bits. With address bit 0 = 0 it returns 9Dh, 2Fh, 7Fh. With bit 0 = 1 it returns 2Fh, 9Dh, 7Fh. Either sequence repeats.
- R8: Opcode ABh takes 24 dummy clocks and then returns 2Fh repeatedly.
- R9: Inputs are captured on rising SCK and outputs change on falling SCK, both with SCK idling low and with SCK idling high.
- R10: A hold input driven low while SCK is low pauses the sequence. The outputs are released, SCK edges and input bits are ignored, and the sequence resumes at the same bit once hold is raised while SCK is low.
- R11: A rise of chip select aborts any partial sequence. The next selection starts decoding a fresh opcode.
- R12: An opcode that is not one of the six reads produces exactly one cmd_valid_o pulse carrying the opcode on cmd_code_o. The read opcodes produce none.
- R13: While busy_i is high, read opcodes are ignored (no array read, no output drive), opcode 05h is still strobed out, and every other opcode is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x SCK |
| rst_n | input | 1 | Synchronous active-low reset |
| sck_i | input | 1 | Serial clock pin |
| cs_n_i | input | 1 | Chip select pin, active low |
| hold_n_i | input | 1 | Hold pin, active low |
| si_i | input | 1 | Serial data input |
| so_o | output | 1 | Serial data output (higher bit in dual mode) |
| so_oe | output | 1 | Output enable for so_o |
| sio_o | output | 1 | Second data pin output (lower bit in dual mode) |
| sio_oe | output | 1 | Output enable for sio_o |
| busy_i | input | 1 | Program/erase/status engine busy |
| mem_rd_o | output | 1 | Array read strobe |
| mem_addr_o | output | 15 | Array byte address |
| mem_data_i | input | 8 | Array read data, one cycle after the strobe |
| cmd_valid_o | output | 1 | One-cycle strobe for a passed-on opcode |
| cmd_code_o | output | 8 | Passed-on opcode |

## Verification
Some properties are checked by assertions on every cycle. The outputs are released while chip select is high, and the outputs stay frozen while hold is active. A command strobe never lasts two cycles, and a strobe decoded while busy carries only 05h. The sio pin is never driven without the so pin, and array read strobes are single cycles. Only the bench scenarios can show the byte contents and ordering. That covers address masking and wrap, the dummy counts, pairing of bits in dual mode, the three identification sequences, mode 3 clocking and resumption after a hold. It also covers decoding that restarts after an abort, with values compared against bench-computed expectations.

// File: rtl/spi_rd_pkg.sv
// Shared opcodes and phase types for the SPI read-path front end.
package spi_rd_pkg;
    localparam logic [7:0] OP_READ   = 8'h03;
    localparam logic [7:0] OP_FAST   = 8'h0B;
    localparam logic [7:0] OP_DUAL   = 8'h3B;
    localparam logic [7:0] OP_JEDEC  = 8'h9F;
    localparam logic [7:0] OP_MDID   = 8'h90;
    localparam logic [7:0] OP_LEGACY = 8'hAB;
    localparam logic [7:0] OP_STATUS = 8'h05;

    typedef enum logic [2:0] {PH_OPC, PH_ADDR, PH_DUMMY, PH_DATA, PH_SKIP} phase_t;
    typedef enum logic [1:0] {SRC_MEM, SRC_JEDEC, SRC_MDID, SRC_LEGACY} src_t;
endpackage

// File: rtl/spi_rd_sync.sv
// Multi-stage synchronizer for a vector of asynchronous pins.
// Assumes each bit is independent; RST_VAL gives the idle level of each pin.
module spi_rd_sync #(
    parameter int          W       = 4,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            // Shift the pin value one flop further down the chain.
            always_ff @(posedge clk) begin
                if (!rst_n) stage[s] <= RST_VAL;
                else        stage[s] <= (s == 0) ? d : stage[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    assign q = stage[STAGES-1];
endmodule

// File: rtl/spi_rd_ctrl.sv
// Serial sequencer: collects opcode, address and dummy bits on rising SCK,
// decides the byte source and issues one fetch per output byte.
// Assumes rise is already gated by chip select and hold.
module spi_rd_ctrl
    import spi_rd_pkg::*;
#(
    parameter int          ADDR_W       = 15,
    parameter int          HDR_BITS     = 24,
    parameter int          FAST_DUMMY   = 8,
    parameter int          LEGACY_DUMMY = 24,
    parameter logic [7:0]  MFR_ID       = 8'h9D,
    parameter logic [7:0]  CONT_ID      = 8'h7F,
    parameter logic [7:0]  DEV_ID       = 8'h2F
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_s,
    input  logic              rise,
    input  logic              din,
    input  logic              busy_i,
    input  logic              byte_load,
    output logic              in_data,
    output logic              dual,
    output logic              fetch_q,
    output logic              src_mem,
    output logic [7:0]        id_val,
    output logic              mem_rd_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic              cmd_valid_o,
    output logic [7:0]        cmd_code_o
);
    localparam int CNT_W = $clog2(HDR_BITS > LEGACY_DUMMY ? HDR_BITS : LEGACY_DUMMY) + 1;

    phase_t            phase;
    src_t              src;
    logic [CNT_W-1:0]  cnt;
    logic [CNT_W-1:0]  dum_last;
    logic              need_dummy;
    logic [6:0]        opc_sr;
    logic [ADDR_W-1:0] addr;
    logic [1:0]        id_idx;
    logic [7:0]        opc_w;

    assign opc_w = {opc_sr, din};

    // Sequence state: phase walk, address capture, fetch and strobe generation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_OPC; src <= SRC_MEM; cnt <= '0; dum_last <= '0;
            need_dummy <= 1'b0; opc_sr <= '0; addr <= '0; id_idx <= '0;
            dual <= 1'b0; fetch_q <= 1'b0; cmd_valid_o <= 1'b0; cmd_code_o <= '0;
        end else begin
            cmd_valid_o <= 1'b0;
            fetch_q     <= byte_load;
            if (fetch_q) begin
                if (src == SRC_MEM) addr <= addr + 1'b1;
                else                id_idx <= (id_idx == 2'd2) ? 2'd0 : id_idx + 2'd1;
            end
            if (cs_s) begin
                phase <= PH_OPC; cnt <= '0; fetch_q <= 1'b0; id_idx <= '0; dual <= 1'b0;
            end else if (rise) begin
                case (phase)
                    PH_OPC: begin
                        opc_sr <= opc_w[6:0];
                        cnt    <= cnt + 1'b1;
                        if (cnt == CNT_W'(7)) begin
                            cnt <= '0;
                            need_dummy <= 1'b0;
                            dum_last   <= CNT_W'(FAST_DUMMY - 1);
                            if (busy_i) begin
                                phase <= PH_SKIP;
                                if (opc_w == OP_STATUS) begin
                                    cmd_valid_o <= 1'b1; cmd_code_o <= opc_w;
                                end
                            end else begin
                                case (opc_w)
                                    OP_READ:  begin phase <= PH_ADDR; src <= SRC_MEM; end
                                    OP_FAST:  begin phase <= PH_ADDR; src <= SRC_MEM; need_dummy <= 1'b1; end
                                    OP_DUAL:  begin phase <= PH_ADDR; src <= SRC_MEM; need_dummy <= 1'b1; dual <= 1'b1; end
                                    OP_MDID:  begin phase <= PH_ADDR; src <= SRC_MDID; end
                                    OP_LEGACY: begin
                                        phase <= PH_DUMMY; src <= SRC_LEGACY;
                                        dum_last <= CNT_W'(LEGACY_DUMMY - 1);
                                    end
                                    OP_JEDEC: begin phase <= PH_DATA; src <= SRC_JEDEC; fetch_q <= 1'b1; end
                                    default: begin
                                        phase <= PH_SKIP;
                                        cmd_valid_o <= 1'b1; cmd_code_o <= opc_w;
                                    end
                                endcase
                            end
                        end
                    end
                    PH_ADDR: begin
                        addr <= {addr[ADDR_W-2:0], din};
                        cnt  <= cnt + 1'b1;
                        if (cnt == CNT_W'(HDR_BITS - 1)) begin
                            cnt <= '0;
                            if (need_dummy) phase <= PH_DUMMY;
                            else begin phase <= PH_DATA; fetch_q <= 1'b1; end
                        end
                    end
                    PH_DUMMY: begin
                        cnt <= cnt + 1'b1;
                        if (cnt == dum_last) begin
                            cnt <= '0; phase <= PH_DATA; fetch_q <= 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // Identification byte selected by source, index and address bit 0.
    always_comb begin
        id_val = DEV_ID;
        case (src)
            SRC_JEDEC: id_val = (id_idx == 2'd0) ? CONT_ID : (id_idx == 2'd1) ? MFR_ID : DEV_ID;
            SRC_MDID:  id_val = (id_idx == 2'd2) ? CONT_ID :
                                ((id_idx == 2'd0) ^ addr[0]) ? MFR_ID : DEV_ID;
            default:   id_val = DEV_ID;
        endcase
    end

    assign in_data    = (phase == PH_DATA);
    assign src_mem    = (src == SRC_MEM);
    assign mem_rd_o   = fetch_q & src_mem;
    assign mem_addr_o = addr;
endmodule

// File: rtl/spi_rd_out.sv
// Output shifter: holds the next byte (from the array port or the ID table)
// and shifts one or two bits out per falling SCK edge.
// Assumes fall is already gated by chip select and hold.
module spi_rd_out (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_s,
    input  logic       fall,
    input  logic       in_data,
    input  logic       dual,
    input  logic       fetch_q,
    input  logic       src_mem,
    input  logic [7:0] id_val,
    input  logic [7:0] mem_data_i,
    output logic       so_bit,
    output logic       sio_bit,
    output logic       started,
    output logic       byte_load
);
    logic [7:0] nxt;
    logic [7:0] sh;
    logic [2:0] pos;
    logic       rd_pend;

    assign byte_load = fall & in_data & (pos == 3'd0);

    // Prefetch buffer and bit shifter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nxt <= '0; sh <= '0; pos <= '0; rd_pend <= 1'b0; started <= 1'b0;
        end else begin
            rd_pend <= fetch_q & src_mem;
            if (fetch_q && !src_mem) nxt <= id_val;
            if (rd_pend)             nxt <= mem_data_i;
            if (cs_s) begin
                pos <= '0; started <= 1'b0;
            end else if (fall && in_data) begin
                started <= 1'b1;
                if (pos == 3'd0) sh <= rd_pend ? mem_data_i : nxt;
                else             sh <= dual ? {sh[5:0], 2'b00} : {sh[6:0], 1'b0};
                pos <= pos + (dual ? 3'd2 : 3'd1);
            end
        end
    end

    assign so_bit  = sh[7];
    assign sio_bit = sh[6];
endmodule

// File: rtl/spi_rd_frontend.sv
// Top of the SPI read-path front end. Synchronizes the pins, derives gated
// SCK edges and the hold state, and joins sequencer and output shifter.
// Assumes clk runs at least 4x SCK; array port answers one cycle after mem_rd_o.
module spi_rd_frontend #(
    parameter int ADDR_W      = 15,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck_i,
    input  logic              cs_n_i,
    input  logic              hold_n_i,
    input  logic              si_i,
    output logic              so_o,
    output logic              so_oe,
    output logic              sio_o,
    output logic              sio_oe,
    input  logic              busy_i,
    output logic              mem_rd_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    input  logic [7:0]        mem_data_i,
    output logic              cmd_valid_o,
    output logic [7:0]        cmd_code_o
);
    logic [3:0] sync_q;
    logic sck_s, cs_s, hold_s, din_s;
    logic sck_d, hold_q, rise, fall;
    logic in_data, dual, fetch_q, src_mem, started, byte_load;
    logic [7:0] id_val;

    spi_rd_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b0110)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .d({si_i, hold_n_i, cs_n_i, sck_i}), .q(sync_q)
    );
    assign sck_s  = sync_q[0];
    assign cs_s   = sync_q[1];
    assign hold_s = ~sync_q[2];
    assign din_s  = sync_q[3];

    // SCK edge memory and hold state, which only changes while SCK is low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_d <= 1'b0; hold_q <= 1'b0;
        end else begin
            sck_d <= sck_s;
            if (!sck_s) hold_q <= hold_s;
        end
    end

    assign rise = sck_s & ~sck_d & ~cs_s & ~hold_q;
    assign fall = ~sck_s & sck_d & ~cs_s & ~hold_q;

    spi_rd_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .rise(rise), .din(din_s),
        .busy_i(busy_i), .byte_load(byte_load), .in_data(in_data), .dual(dual),
        .fetch_q(fetch_q), .src_mem(src_mem), .id_val(id_val),
        .mem_rd_o(mem_rd_o), .mem_addr_o(mem_addr_o),
        .cmd_valid_o(cmd_valid_o), .cmd_code_o(cmd_code_o)
    );

    spi_rd_out u_out (
        .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .fall(fall), .in_data(in_data),
        .dual(dual), .fetch_q(fetch_q), .src_mem(src_mem), .id_val(id_val),
        .mem_data_i(mem_data_i), .so_bit(so_o), .sio_bit(sio_o),
        .started(started), .byte_load(byte_load)
    );

    assign so_oe  = started & in_data & ~cs_s & ~hold_q;
    assign sio_oe = so_oe & dual;
endmodule

// File: rtl/spi_rd_chk.sv
// Checker for the SPI read-path front end, bound to the top module.
module spi_rd_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cs_s,
    input logic       hold_q,
    input logic       so_o,
    input logic       sio_o,
    input logic       so_oe,
    input logic       sio_oe,
    input logic       busy_i,
    input logic       mem_rd_o,
    input logic       cmd_valid_o,
    input logic [7:0] cmd_code_o
);
    AST_DESELECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        cs_s |-> (!so_oe && !sio_oe)); // R1
    AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        hold_q |=> ($stable(so_o) && $stable(sio_o))); // R10
    AST_CMD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_o |=> !cmd_valid_o); // R12
    AST_BUSY_STATUS_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_o && $past(busy_i)) |-> (cmd_code_o == 8'h05)); // R13
    AST_DUAL_PAIRED: assert property (@(posedge clk) disable iff (!rst_n)
        sio_oe |-> so_oe); // R5
    AST_FETCH_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_o |=> !mem_rd_o); // R3
endmodule

bind spi_rd_frontend spi_rd_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .hold_q(hold_q),
    .so_o(so_o), .sio_o(sio_o), .so_oe(so_oe), .sio_oe(sio_oe),
    .busy_i(busy_i), .mem_rd_o(mem_rd_o),
    .cmd_valid_o(cmd_valid_o), .cmd_code_o(cmd_code_o)
);

// File: tb/spi_rd_frontend_bench.sv
module spi_rd_frontend_bench;
    localparam int CLK_P = 10;
    localparam int H     = 6;

    logic clk = 1'b0, rst_n = 1'b0;
    logic sck = 1'b0, cs_n = 1'b1, hold_n = 1'b1, si = 1'b0, busy = 1'b0;
    logic so_o, so_oe, sio_o, sio_oe, mem_rd_o, cmd_valid_o;
    logic [14:0] mem_addr_o;
    logic [7:0]  mem_data_i = 8'h00, cmd_code_o;

    int checks = 0, errors = 0, cmd_cnt = 0, rd_cnt = 0;
    logic [7:0] last_code = 8'h00;
    logic [7:0] tx [8];
    logic [7:0] rx [16];
    bit oe_bad, oe_seen, hold_bad, done = 0;

    always #(CLK_P/2) clk = ~clk;

    spi_rd_frontend u_spi_rd_frontend (
        .clk(clk), .rst_n(rst_n), .sck_i(sck), .cs_n_i(cs_n), .hold_n_i(hold_n),
        .si_i(si), .so_o(so_o), .so_oe(so_oe), .sio_o(sio_o), .sio_oe(sio_oe),
        .busy_i(busy), .mem_rd_o(mem_rd_o), .mem_addr_o(mem_addr_o),
        .mem_data_i(mem_data_i), .cmd_valid_o(cmd_valid_o), .cmd_code_o(cmd_code_o)
    );

    function automatic logic [7:0] memf(input logic [14:0] a);
        return a[7:0] ^ {a[14:8], 1'b1} ^ 8'h5A;
    endfunction

    always @(posedge clk) begin
        if (mem_rd_o) mem_data_i <= memf(mem_addr_o);
        if (mem_rd_o) rd_cnt <= rd_cnt + 1;
        if (cmd_valid_o) begin cmd_cnt <= cmd_cnt + 1; last_code <= cmd_code_o; end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic half();
        repeat (H) @(negedge clk);
    endtask

    task automatic set_hdr(input logic [7:0] op, input logic [23:0] a);
        tx[0] = op; tx[1] = a[23:16]; tx[2] = a[15:8]; tx[3] = a[7:0];
        tx[4] = 8'h00; tx[5] = 8'h00; tx[6] = 8'h00; tx[7] = 8'h00;
    endtask

    // One selection: nhdr header bits from tx, then nrd output bytes into rx.
    task automatic txn(input bit m3, input int nhdr, input int nrd, input bit dual, input bit do_hold);
        int nout;
        nout = dual ? nrd * 4 : nrd * 8;
        oe_bad = 0; oe_seen = 0; hold_bad = 0;
        @(negedge clk); sck = m3; half();
        cs_n = 1'b0; half();
        if (m3) begin sck = 1'b0; half(); end
        for (int i = 0; i < nhdr + nout; i++) begin
            if (i < nhdr) si = tx[i/8][7-(i%8)];
            else          si = 1'($urandom);
            half();
            if (i >= nhdr) begin
                int j;
                j = i - nhdr;
                if (dual) begin
                    rx[j/4][7-2*(j%4)] = so_o;
                    rx[j/4][6-2*(j%4)] = sio_o;
                end else begin
                    rx[j/8][7-(j%8)] = so_o;
                end
                if (so_oe) oe_seen = 1;
                if (!so_oe || (dual != sio_oe)) oe_bad = 1;
            end
            sck = 1'b1; half(); sck = 1'b0;
            if (do_hold && i == nhdr + 2) begin
                hold_n = 1'b0; half();
                for (int k = 0; k < 3; k++) begin
                    si = 1'($urandom); sck = 1'b1; half();
                    if (so_oe) hold_bad = 1;
                    sck = 1'b0; half();
                    if (so_oe) hold_bad = 1;
                end
                hold_n = 1'b1; half();
            end
        end
        half();
        if (m3) sck = 1'b1;
        half(); cs_n = 1'b1; half(); half();
    endtask

    task automatic mem_read(input bit m3, input logic [7:0] op, input logic [23:0] a,
                            input int nrd, input bit hold, input string tag);
        bit dual, dum;
        logic [14:0] ea;
        dual = (op == 8'h3B);
        dum  = (op != 8'h03);
        set_hdr(op, a);
        txn(m3, dum ? 40 : 32, nrd, dual, hold);
        for (int k = 0; k < nrd; k++) begin
            ea = a[14:0] + 15'(k);
            chk(tag, {24'h0, rx[k]}, {24'h0, memf(ea)});
        end
        chk({tag, " oe"}, {31'h0, oe_bad}, 32'h0);
        chk({tag, " so_oe after deselect R1"}, {31'h0, so_oe}, 32'h0);
    endtask

    initial begin
        int c0, r0;
        repeat (5) @(negedge clk);
        chk("R1 reset so_oe", {31'h0, so_oe}, 0);
        chk("R1 reset sio_oe", {31'h0, sio_oe}, 0);
        chk("R1 reset mem_rd", {31'h0, mem_rd_o}, 0);
        chk("R1 reset cmd_valid", {31'h0, cmd_valid_o}, 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R2 R3: upper address bits ignored, wrap from 7FFF to 0000
        mem_read(0, 8'h03, 24'hFF7FFE, 4, 0, "R2 R3 normal read wrap");
        chk("R12 read opcode not forwarded", cmd_cnt, 0);
        // R4 R9: fast read in idle-high clock mode
        mem_read(1, 8'h0B, 24'h001234, 3, 0, "R4 R9 fast read mode 3");
        // R5: dual output across the wrap point
        mem_read(0, 8'h3B, 24'h007FFF, 3, 0, "R5 dual read");
        mem_read(1, 8'h3B, 24'hA50A0F, 2, 0, "R5 R9 dual read mode 3");

        // R6: JEDEC ID loop
        set_hdr(8'h9F, 24'h0);
        txn(0, 8, 6, 0, 0);
        chk("R6 id0", rx[0], 8'h7F); chk("R6 id1", rx[1], 8'h9D); chk("R6 id2", rx[2], 8'h2F);
        chk("R6 loop0", rx[3], 8'h7F); chk("R6 loop2", rx[5], 8'h2F);
        // R7: address bit 0 picks the order
        set_hdr(8'h90, 24'h000000);
        txn(1, 32, 4, 0, 0);
        chk("R7 a0=0 b0", rx[0], 8'h9D); chk("R7 a0=0 b1", rx[1], 8'h2F);
        chk("R7 a0=0 b2", rx[2], 8'h7F); chk("R7 a0=0 loop", rx[3], 8'h9D);
        set_hdr(8'h90, 24'h000001);
        txn(0, 32, 4, 0, 0);
        chk("R7 a0=1 b0", rx[0], 8'h2F); chk("R7 a0=1 b1", rx[1], 8'h9D);
        chk("R7 a0=1 b2", rx[2], 8'h7F); chk("R7 a0=1 loop", rx[3], 8'h2F);
        // R8: legacy ID after 24 dummy clocks
        set_hdr(8'hAB, 24'hFFFFFF);
        txn(0, 32, 3, 0, 0);
        chk("R8 legacy b0", rx[0], 8'h2F); chk("R8 legacy b2", rx[2], 8'h2F);

        // R10: hold in the middle of a data byte
        mem_read(0, 8'h03, 24'h000321, 2, 1, "R10 hold read");
        chk("R10 outputs released in hold", {31'h0, hold_bad}, 0);

        // R11: abort mid-address, then fresh decode
        c0 = cmd_cnt; r0 = rd_cnt;
        set_hdr(8'h03, 24'h123456);
        txn(0, 13, 0, 0, 0);
        chk("R11 abort no read", rd_cnt, r0);
        chk("R11 abort no strobe", cmd_cnt, c0);
        set_hdr(8'h9F, 24'h0);
        txn(0, 8, 1, 0, 0);
        chk("R11 fresh decode after abort", rx[0], 8'h7F);

        // R12: non-read opcode forwarded once
        c0 = cmd_cnt;
        set_hdr(8'h06, 24'h0);
        txn(0, 8, 0, 0, 0);
        chk("R12 strobe count", cmd_cnt, c0 + 1);
        chk("R12 strobe code", last_code, 8'h06);

        // R13: busy gating
        busy = 1'b1;
        c0 = cmd_cnt; r0 = rd_cnt;
        set_hdr(8'h03, 24'h000010);
        txn(0, 32, 1, 0, 0);
        chk("R13 busy read no fetch", rd_cnt, r0);
        chk("R13 busy read no drive", {31'h0, oe_seen}, 0);
        set_hdr(8'h05, 24'h0);
        txn(0, 8, 0, 0, 0);
        chk("R13 busy status forwarded", cmd_cnt, c0 + 1);
        chk("R13 busy status code", last_code, 8'h05);
        set_hdr(8'h06, 24'h0);
        txn(0, 8, 0, 0, 0);
        chk("R13 busy other dropped", cmd_cnt, c0 + 1);
        busy = 1'b0;

        // Random reads over all three memory opcodes and both clock modes
        void'($urandom(32'h5EED));
        for (int n = 0; n < 16; n++) begin
            logic [7:0] op;
            int sel;
            sel = int'($urandom % 3);
            op = (sel == 0) ? 8'h03 : (sel == 1) ? 8'h0B : 8'h3B;
            mem_read(1'($urandom), op, 24'($urandom), 1 + int'($urandom % 4), 0,
                     "R2 R4 R5 R9 random read");
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (180000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule